// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Output Loader

This block sits behind a serial receiver and in front of a two-channel converter model. Each complete 24-bit command word arrives with a single-cycle valid pulse. The word holds an 8-bit control byte in its upper bits and a 16-bit data field in its lower bits. The block keeps three pieces of state for each channel: a staging buffer, an active output code and an operating mode. The active code and the mode drive the converter directly.

A command always writes one staging buffer, chosen by a select bit. It can also carry one load bit per channel. A set load bit copies that channel's staging buffer into its active code and mode. Because of this, one frame can stage a value for one channel and then commit both channels together. Two frames in a row can instead update the channels one after the other.

Data and power-down requests travel the same path through the buffer. A power-down request changes the outputs only when a load commits it. While a channel is powered down, its active code keeps the last data value it received.

Top module: `dual_load_ctrl`

## Requirements
- R1: After reset, both active codes are 0, both modes are 00 (normal), both update strobes are 0 and the error flag is 0.
- R2: A valid frame with bit 20 and bit 21 both 0 only changes a staging buffer. Neither active code nor mode changes, and neither strobe fires.
- R3: Bit 18 picks the staging buffer: 0 writes channel A and 1 writes channel B. When bits 17:16 are 00, the buffer takes data bits 15:0 and normal mode.
- R4: Bit 20 loads channel A and bit 21 loads channel B from its staging buffer. The buffer value used is the one after this frame's own write, so a single frame can write buffer B and load both channels.
- R5: When bits 17:16 are not 00, the addressed buffer stores that code as its mode and ignores data bits 15:0. Mode codes are: 01 means ground through about 1k, 10 means ground through about 100k, and 11 means high impedance. A load of such a buffer sets the mode and leaves the active code unchanged.
- R6: A powered-down channel returns to normal mode only when it is loaded from a buffer last written with code 00. That load takes the new data as its active code.
- R7: A valid frame with bits 23:22 not 00 changes no buffer and no output, fires no strobe, and sets an error flag. The flag stays set until reset.
- R8: Active code and mode change on the first clock edge after the valid cycle. In that same cycle the loaded channel's update strobe is high, and only for one cycle.
- R9: Bit 19 has no effect on any buffer, output or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse marking a complete command word |
| cmd_word_i | input | 24 | Control byte in bits 23:16, data in bits 15:0 |
| code_a_o | output | 16 | Active output code, channel A |
| mode_a_o | output | 2 | Active operating mode, channel A |
| code_b_o | output | 16 | Active output code, channel B |
| mode_b_o | output | 2 | Active operating mode, channel B |
| upd_a_o | output | 1 | One-cycle strobe when channel A is loaded |
| upd_b_o | output | 1 | One-cycle strobe when channel B is loaded |
| cmd_err_o | output | 1 | Sticky flag for a frame with nonzero reserved bits |

## Verification
Two functions can fall in the same cycle: the buffer write and the load of that same buffer. The load must see the value the frame is writing, not the buffer's previous contents. The bench sweeps every combination of the two load bits, the select bit, bit 19 and the mode code, with a new data value each frame. In this way every write-and-load overlap happens, including frames that write one channel and load the other or both. After each frame, both channels' codes, modes and strobes are compared with an arithmetic model of the staging and active state.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_GND_LOW  = 2'b01,
    MODE_GND_HIGH = 2'b10,
    MODE_FLOAT    = 2'b11
  } mode_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic       load_b;
    logic       load_a;
    logic       spare;
    logic       sel_b;
    mode_e      pd;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dlc_decode.sv
module dlc_decode
  import dlc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = DATA_W + CTRL_W
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NUM_CH-1:0] wr_o,
  output logic [NUM_CH-1:0] ld_o,
  output mode_e             pd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bad_o
);
  ctrl_t ctrl;
  logic  ok;
  logic  unused_spare;

  assign ctrl         = ctrl_t'(word_i[WORD_W-1:DATA_W]);
  assign data_o       = word_i[DATA_W-1:0];
  assign pd_o         = ctrl.pd;
  assign ok           = valid_i && (ctrl.rsvd == 2'b00);
  assign bad_o        = valid_i && (ctrl.rsvd != 2'b00);
  assign unused_spare = ctrl.spare;
  assign ld_o         = ok ? {ctrl.load_b, ctrl.load_a} : '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign wr_o[i] = ok && (ctrl.sel_b == 1'(i));
  end
endmodule

// File: rtl/dlc_channel.sv
module dlc_channel
  import dlc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              ld_i,
  input  mode_e             pd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o,
  output mode_e             mode_o,
  output logic              upd_o
);
  logic [DATA_W-1:0] stg_data_q, stg_data_d;
  mode_e             stg_mode_q, stg_mode_d;

  // staged value as seen after this frame's write (load uses it)
  always_comb begin
    stg_data_d = stg_data_q;
    stg_mode_d = stg_mode_q;
    if (wr_i) begin
      stg_mode_d = pd_i;
      if (pd_i == MODE_RUN) stg_data_d = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_data_q <= '0;
      stg_mode_q <= MODE_RUN;
      code_o     <= '0;
      mode_o     <= MODE_RUN;
      upd_o      <= 1'b0;
    end else begin
      stg_data_q <= stg_data_d;
      stg_mode_q <= stg_mode_d;
      upd_o      <= ld_i;
      if (ld_i) begin
        mode_o <= stg_mode_d;
        if (stg_mode_d == MODE_RUN) code_o <= stg_data_d;
      end
    end
  end
endmodule

// File: rtl/dual_load_ctrl.sv
module dual_load_ctrl
  import dlc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = DATA_W + CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic [DATA_W-1:0] code_a_o,
  output logic [1:0]        mode_a_o,
  output logic [DATA_W-1:0] code_b_o,
  output logic [1:0]        mode_b_o,
  output logic              upd_a_o,
  output logic              upd_b_o,
  output logic              cmd_err_o
);
  logic [NUM_CH-1:0] wr, ld, upd;
  mode_e             pd;
  logic [DATA_W-1:0] data;
  logic              bad;
  logic [DATA_W-1:0] code [NUM_CH];
  mode_e             mode [NUM_CH];

  dlc_decode #(.DATA_W(DATA_W)) i_decode (
    .valid_i (cmd_valid_i),
    .word_i  (cmd_word_i),
    .wr_o    (wr),
    .ld_o    (ld),
    .pd_o    (pd),
    .data_o  (data),
    .bad_o   (bad)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dlc_channel #(.DATA_W(DATA_W)) i_channel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr[i]),
      .ld_i   (ld[i]),
      .pd_i   (pd),
      .data_i (data),
      .code_o (code[i]),
      .mode_o (mode[i]),
      .upd_o  (upd[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cmd_err_o <= 1'b0;
    else if (bad) cmd_err_o <= 1'b1;
  end

  assign code_a_o = code[0];
  assign mode_a_o = mode[0];
  assign upd_a_o  = upd[0];
  assign code_b_o = code[1];
  assign mode_b_o = mode[1];
  assign upd_b_o  = upd[1];
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = DATA_W + 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [WORD_W-1:0] cmd_word_i,
  input logic [DATA_W-1:0] code_a_o,
  input logic [1:0]        mode_a_o,
  input logic [DATA_W-1:0] code_b_o,
  input logic [1:0]        mode_b_o,
  input logic              upd_a_o,
  input logic              upd_b_o,
  input logic              cmd_err_o
);
  localparam int unsigned RS = WORD_W - 2;
  localparam int unsigned LA = DATA_W + 4;
  localparam int unsigned LB = DATA_W + 5;

  assert_strobe_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_a_o || upd_b_o) |-> $past(cmd_valid_i));

  assert_hold_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_a_o |-> ($stable(code_a_o) && $stable(mode_a_o)));

  assert_hold_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_b_o |-> ($stable(code_b_o) && $stable(mode_b_o)));

  assert_no_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_word_i[LA] && !cmd_word_i[LB]) |=> (!upd_a_o && !upd_b_o));

  assert_load_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[WORD_W-1:RS] == 2'b00 && cmd_word_i[LA]) |=> upd_a_o);

  assert_load_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[WORD_W-1:RS] == 2'b00 && cmd_word_i[LB]) |=> upd_b_o);

  assert_pd_keep_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_a_o && mode_a_o != 2'b00) |-> $stable(code_a_o));

  assert_pd_keep_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_b_o && mode_b_o != 2'b00) |-> $stable(code_b_o));

  assert_reserved_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_word_i[WORD_W-1:RS] != 2'b00) |=> (cmd_err_o && !upd_a_o && !upd_b_o));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |=> cmd_err_o);
endmodule

bind dual_load_ctrl dlc_checker #(.DATA_W(DATA_W)) i_dlc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_word_i  (cmd_word_i),
  .code_a_o    (code_a_o),
  .mode_a_o    (mode_a_o),
  .code_b_o    (code_b_o),
  .mode_b_o    (mode_b_o),
  .upd_a_o     (upd_a_o),
  .upd_b_o     (upd_b_o),
  .cmd_err_o   (cmd_err_o)
);

// File: tb/test_dual_load_ctrl.sv
module test_dual_load_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [15:0] code_a, code_b;
  logic [1:0]  mode_a, mode_b;
  logic        upd_a, upd_b, cmd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_bd [2];
  logic [1:0]  m_bm [2];
  logic [15:0] m_ac [2];
  logic [1:0]  m_am [2];
  logic        m_up [2];
  logic        m_err;

  always #5 clk = ~clk;

  dual_load_ctrl i_dual_load_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_word_i  (cmd_word),
    .code_a_o    (code_a),
    .mode_a_o    (mode_a),
    .code_b_o    (code_b),
    .mode_b_o    (mode_b),
    .upd_a_o     (upd_a),
    .upd_b_o     (upd_b),
    .cmd_err_o   (cmd_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [23:0] w);
    logic sel;
    m_up[0] = 1'b0;
    m_up[1] = 1'b0;
    if (w[23:22] != 2'b00) begin
      m_err = 1'b1;
      return;
    end
    sel = w[18];
    m_bm[sel] = w[17:16];
    if (w[17:16] == 2'b00) m_bd[sel] = w[15:0];
    for (int c = 0; c < 2; c++) begin
      if (w[20+c]) begin
        m_up[c] = 1'b1;
        m_am[c] = m_bm[c];
        if (m_bm[c] == 2'b00) m_ac[c] = m_bd[c];
      end
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3/R4/R5"}, "code_a", 32'(code_a), 32'(m_ac[0]));
    chk({tag, " R3/R4/R5"}, "code_b", 32'(code_b), 32'(m_ac[1]));
    chk({tag, " R5/R6"}, "mode_a", 32'(mode_a), 32'(m_am[0]));
    chk({tag, " R5/R6"}, "mode_b", 32'(mode_b), 32'(m_am[1]));
    chk({tag, " R8"}, "upd_a", 32'(upd_a), 32'(m_up[0]));
    chk({tag, " R8"}, "upd_b", 32'(upd_b), 32'(m_up[1]));
    chk({tag, " R7"}, "err", 32'(cmd_err), 32'(m_err));
  endtask

  // drive on falling edge, result visible at the next falling edge
  task automatic send(input logic [23:0] w, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    model(w);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
    check_all(tag);
    @(negedge clk);
    chk("R8", "upd_a one cycle", 32'(upd_a), 32'd0);
    chk("R8", "upd_b one cycle", 32'(upd_b), 32'd0);
  endtask

  function automatic logic [23:0] mk(input logic [1:0] rs, input logic lb, input logic la,
                                     input logic sp, input logic sb, input logic [1:0] pd,
                                     input logic [15:0] d);
    return {rs, lb, la, sp, sb, pd, d};
  endfunction

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_bd[c] = '0; m_bm[c] = '0; m_ac[c] = '0; m_am[c] = '0; m_up[c] = 1'b0;
    end
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2: write only, outputs unchanged
    send(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 16'h1234), "R2 stage A");
    send(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'hBEEF), "R2 stage B");
    // R4: write B and load both in one frame
    send(mk(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 16'hCAFE), "R4 write B load both");
    chk("R4", "simultaneous code_a", 32'(code_a), 32'h1234);
    chk("R4", "simultaneous code_b", 32'(code_b), 32'hCAFE);
    // R5: power-down A to high impedance, code held
    send(mk(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 16'hFFFF), "R5 pd A");
    chk("R5", "pd keeps code_a", 32'(code_a), 32'h1234);
    chk("R5", "pd mode_a", 32'(mode_a), 32'h3);
    // R6: load A alone without a run write keeps power-down
    send(mk(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 16'h0042), "R6 reload A");
    chk("R6", "still down", 32'(mode_a), 32'h3);
    send(mk(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 16'h5A5A), "R6 wake A");
    chk("R6", "woke mode_a", 32'(mode_a), 32'h0);
    chk("R6", "woke code_a", 32'(code_a), 32'h5A5A);

    // sweep of all control patterns; bit 19 toggled per pattern (R9)
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < 2; s++) begin
        logic [5:0] cb = 6'(p);
        send(mk(2'b00, cb[5], cb[4], 1'(s), cb[2], cb[1:0],
                16'(p * 1031 + s * 4099 + 7)), cb[3] ? "R9 sweep" : "sweep");
      end
    end

    // R7: reserved bits set, ignored and sticky
    for (int r = 1; r < 4; r++) begin
      send(mk(2'(r), 1'b1, 1'b1, 1'b0, 1'(r), 2'b00, 16'(r * 777)), "R7 reserved");
    end
    send(mk(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 16'h7777), "R7 sticky after good frame");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule